// File: doc/BRIEF.md
# Aligned and Misaligned Word Access Unit

This unit sits between a requester that reads and writes 16-bit words or single bytes at any byte address and a memory that is two bytes wide, with an even lane (byte enable bit 0, data bits 7:0) and an odd lane (byte enable bit 1, data bits 15:8). Words are little-endian: the low byte lives at the lower byte address. For example, the value 625A stores 5A at the even address and 62 at the next one.

A word whose start address has bit 0 clear is aligned and takes one bus cycle with both lanes enabled. A word whose start address has bit 0 set is misaligned and takes two bus cycles. The first cycle carries the low byte on the odd lane of the start word. The second cycle carries the high byte on the even lane of the following word. For reads, the unit reassembles the two halves into one word. A byte request takes one bus cycle on the lane that address bit 0 selects.

Each bus cycle holds until the memory acknowledges it. When the last bus cycle of a request is acknowledged, the unit pulses `done` once and, for a read, updates `rdata`.

Top module: `word_access_unit`

## Requirements
- R1: After reset, `req_ready` is 1 and `mem_valid`, `done` and `rdata` are 0.
- R2: A word request (`req_size`=1) at an even address performs exactly one bus cycle. That cycle has `mem_be`=11, `mem_waddr` equal to the address shifted right by one, and, for a write, `mem_wdata` equal to `req_wdata`.
- R3: A word request at an odd address first performs a bus cycle at word address (address >> 1) with `mem_be`=10. For a write, that cycle drives the low request byte on bits 15:8 and zero on bits 7:0.
- R4: The second bus cycle of an odd-address word uses word address (address >> 1) + 1 and `mem_be`=01. For a write, it drives the high request byte on bits 7:0 and zero on bits 15:8. An odd-address word performs exactly two bus cycles.
- R5: Read data is little-endian. An aligned word read returns the bus word unchanged. A misaligned word read returns {even lane of the second cycle, odd lane of the first cycle}.
- R6: The word address of the second cycle wraps modulo 2^19. A misaligned word at byte address FFFFF uses word address 7FFFF and then 00000.
- R7: A byte request (`req_size`=0) performs one bus cycle with `mem_be`=01 when address bit 0 is 0, and `mem_be`=10 when it is 1. A byte write drives `req_wdata[7:0]` on the enabled lane and zero on the other. A byte read returns the selected lane in `rdata[7:0]`, with the upper bits zero.
- R8: `done` is high for exactly one cycle per request, in the cycle after the final bus cycle is acknowledged. `rdata` changes only when a read completes and otherwise holds its value.
- R9: While `mem_ack` is low, a bus cycle holds `mem_valid`, `mem_waddr`, `mem_be` and `mem_wdata` unchanged.
- R10: `req_ready` is low while a bus cycle is in progress. A request presented while `req_ready` is low is not taken and causes no bus cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; taken when `req_ready` is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 1 | 1 = word, 0 = byte |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 2*BYTE_W | Write data (byte requests use the low byte) |
| req_ready | output | 1 | Unit idle and able to take a request |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 2*BYTE_W | Assembled read data |
| mem_valid | output | 1 | Bus cycle active |
| mem_write | output | 1 | Bus cycle is a write |
| mem_waddr | output | ADDR_W-1 | Word address |
| mem_be | output | 2 | Lane enables (bit 0 even, bit 1 odd) |
| mem_wdata | output | 2*BYTE_W | Lane write data |
| mem_ack | input | 1 | Memory accepts the current bus cycle |
| mem_rdata | input | 2*BYTE_W | Read data, valid in the acknowledging cycle |

## Verification
The checker assumes two things about the inputs:
- The memory returns read data in the same cycle in which it raises `mem_ack`.
- `mem_ack` has meaning only while `mem_valid` is high.

The checker also tracks request size and address bit 0 from its own capture at acceptance, and never from the unit's state. The bench memory meets both assumptions: it derives `mem_ack` from `mem_valid` after a programmable number of wait cycles and reads its byte array combinationally. The bench drives requests only on falling edges and while the unit is idle, except in one deliberate case. In that case it presents a stray write while the unit is busy, to exercise R10.

// File: rtl/wau_pkg.sv
package wau_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_FIRST  = 2'd1,
      ST_SECOND = 2'd2
   } wau_state_e;

   localparam int unsigned LANES = 2;
endpackage

// File: rtl/wau_ctrl.sv
module wau_ctrl
   import wau_pkg::*;
#(
   parameter int unsigned ADDR_W = 20,
   parameter int unsigned BYTE_W = 8,
   localparam int unsigned WORD_W = 2 * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid_i,
   input  logic              req_write_i,
   input  logic              req_size_i,
   input  logic [ADDR_W-1:0] req_addr_i,
   input  logic [WORD_W-1:0] req_wdata_i,
   input  logic              mem_ack_i,
   output wau_state_e        state_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic              write_o,
   output logic              size_o,
   output logic [WORD_W-1:0] wdata_o,
   output logic              split_o,
   output logic              capture_o,
   output logic              finish_o,
   output logic              ready_o
);
   wau_state_e        state_q, state_d;
   logic [ADDR_W-1:0] addr_q;
   logic              write_q, size_q;
   logic [WORD_W-1:0] wdata_q;
   logic              accept, split;

   assign ready_o = (state_q == ST_IDLE);
   assign accept  = req_valid_i && ready_o;
   assign split   = size_q && addr_q[0];

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:   if (accept) state_d = ST_FIRST;
         ST_FIRST:  if (mem_ack_i) state_d = split ? ST_SECOND : ST_IDLE;
         ST_SECOND: if (mem_ack_i) state_d = ST_IDLE;
         default:   state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         addr_q  <= '0;
         write_q <= 1'b0;
         size_q  <= 1'b0;
         wdata_q <= '0;
      end else begin
         state_q <= state_d;
         if (accept) begin
            addr_q  <= req_addr_i;
            write_q <= req_write_i;
            size_q  <= req_size_i;
            wdata_q <= req_wdata_i;
         end
      end
   end

   assign capture_o = (state_q == ST_FIRST) && mem_ack_i && split;
   assign finish_o  = mem_ack_i && (((state_q == ST_FIRST) && !split) ||
                                     (state_q == ST_SECOND));
   assign state_o   = state_q;
   assign addr_o    = addr_q;
   assign write_o   = write_q;
   assign size_o    = size_q;
   assign wdata_o   = wdata_q;
   assign split_o   = split;
endmodule

// File: rtl/wau_steer.sv
module wau_steer
   import wau_pkg::*;
#(
   parameter int unsigned ADDR_W = 20,
   parameter int unsigned BYTE_W = 8,
   localparam int unsigned WORD_W = 2 * BYTE_W
) (
   input  wau_state_e        state_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              write_i,
   input  logic              size_i,
   input  logic [WORD_W-1:0] wdata_i,
   output logic              mem_valid_o,
   output logic              mem_write_o,
   output logic [ADDR_W-2:0] mem_waddr_o,
   output logic [LANES-1:0]  mem_be_o,
   output logic [WORD_W-1:0] mem_wdata_o
);
   logic              second;
   logic [LANES-1:0]  be;
   logic [ADDR_W-2:0] word_base;

   assign second      = (state_i == ST_SECOND);
   assign word_base   = addr_i[ADDR_W-1:1];
   assign mem_valid_o = (state_i != ST_IDLE);
   assign mem_write_o = mem_valid_o && write_i;
   // modulo-2^(ADDR_W-1) increment gives the wrap for the second cycle
   assign mem_waddr_o = word_base + {{(ADDR_W-2){1'b0}}, second};

   always_comb begin
      if (state_i == ST_IDLE)   be = 2'b00;
      else if (!size_i)         be = addr_i[0] ? 2'b10 : 2'b01;
      else if (!addr_i[0])      be = 2'b11;
      else                      be = second ? 2'b01 : 2'b10;
   end
   assign mem_be_o = be;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic src_hi;
      always_comb begin
         if (size_i && !addr_i[0]) src_hi = (l == 1);
         else                      src_hi = size_i && second;
      end
      assign mem_wdata_o[l*BYTE_W +: BYTE_W] = (be[l] && write_i) ?
         (src_hi ? wdata_i[BYTE_W +: BYTE_W] : wdata_i[0 +: BYTE_W]) : '0;
   end
endmodule

// File: rtl/wau_assemble.sv
module wau_assemble #(
   parameter int unsigned BYTE_W = 8,
   localparam int unsigned WORD_W = 2 * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture_i,
   input  logic              finish_i,
   input  logic              write_i,
   input  logic              size_i,
   input  logic              split_i,
   input  logic              addr0_i,
   input  logic [WORD_W-1:0] mem_rdata_i,
   output logic [WORD_W-1:0] rdata_o,
   output logic              done_o
);
   logic [BYTE_W-1:0] low_q;
   logic [WORD_W-1:0] rdata_q, merged;
   logic              done_q;
   logic [BYTE_W-1:0] lane_lo, lane_hi;

   assign lane_lo = mem_rdata_i[0 +: BYTE_W];
   assign lane_hi = mem_rdata_i[BYTE_W +: BYTE_W];

   always_comb begin
      if (!size_i)      merged = {{BYTE_W{1'b0}}, (addr0_i ? lane_hi : lane_lo)};
      else if (split_i) merged = {lane_lo, low_q};
      else              merged = mem_rdata_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         low_q   <= '0;
         rdata_q <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= finish_i;
         if (capture_i) low_q <= lane_hi;
         if (finish_i && !write_i) rdata_q <= merged;
      end
   end

   assign rdata_o = rdata_q;
   assign done_o  = done_q;
endmodule

// File: rtl/word_access_unit.sv
module word_access_unit
   import wau_pkg::*;
#(
   parameter int unsigned ADDR_W = 20,
   parameter int unsigned BYTE_W = 8,
   localparam int unsigned WORD_W = 2 * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic              req_size,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [WORD_W-1:0] req_wdata,
   output logic              req_ready,
   output logic              done,
   output logic [WORD_W-1:0] rdata,
   output logic              mem_valid,
   output logic              mem_write,
   output logic [ADDR_W-2:0] mem_waddr,
   output logic [1:0]        mem_be,
   output logic [WORD_W-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic [WORD_W-1:0] mem_rdata
);
   if (ADDR_W < 2) begin : g_bad_addr
      $error("word_access_unit: ADDR_W must be at least 2");
   end
   if (BYTE_W < 1) begin : g_bad_byte
      $error("word_access_unit: BYTE_W must be at least 1");
   end

   wau_state_e        state;
   logic [ADDR_W-1:0] addr_q;
   logic              write_q, size_q, split, capture, finish;
   logic [WORD_W-1:0] wdata_q;

   wau_ctrl #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid_i (req_valid),
      .req_write_i (req_write),
      .req_size_i  (req_size),
      .req_addr_i  (req_addr),
      .req_wdata_i (req_wdata),
      .mem_ack_i   (mem_ack),
      .state_o     (state),
      .addr_o      (addr_q),
      .write_o     (write_q),
      .size_o      (size_q),
      .wdata_o     (wdata_q),
      .split_o     (split),
      .capture_o   (capture),
      .finish_o    (finish),
      .ready_o     (req_ready)
   );

   wau_steer #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_steer (
      .state_i     (state),
      .addr_i      (addr_q),
      .write_i     (write_q),
      .size_i      (size_q),
      .wdata_i     (wdata_q),
      .mem_valid_o (mem_valid),
      .mem_write_o (mem_write),
      .mem_waddr_o (mem_waddr),
      .mem_be_o    (mem_be),
      .mem_wdata_o (mem_wdata)
   );

   wau_assemble #(.BYTE_W(BYTE_W)) u_asm (
      .clk         (clk),
      .rst_n       (rst_n),
      .capture_i   (capture),
      .finish_i    (finish),
      .write_i     (write_q),
      .size_i      (size_q),
      .split_i     (split),
      .addr0_i     (addr_q[0]),
      .mem_rdata_i (mem_rdata),
      .rdata_o     (rdata),
      .done_o      (done)
   );
endmodule

// File: rtl/wau_checker.sv
module wau_checker #(
   parameter int unsigned ADDR_W = 20,
   parameter int unsigned BYTE_W = 8,
   localparam int unsigned WORD_W = 2 * BYTE_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              req_size,
   input logic              a0_i,
   input logic              mem_valid,
   input logic              mem_ack,
   input logic [1:0]        mem_be,
   input logic [ADDR_W-2:0] mem_waddr,
   input logic [WORD_W-1:0] mem_wdata,
   input logic              done
);
   logic word_q, odd_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word_q <= 1'b0;
         odd_q  <= 1'b0;
      end else if (req_valid && req_ready) begin
         word_q <= req_size;
         odd_q  <= a0_i;
      end
   end

   p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid |-> !req_ready);

   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_ack) |=> (mem_valid && $stable(mem_waddr) &&
                                   $stable(mem_be) && $stable(mem_wdata)));

   p_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && word_q && !odd_q) |-> (mem_be == 2'b11));

   p_split_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && word_q && odd_q && $past(req_ready)) |-> (mem_be == 2'b10));

   // R6 wrap follows from the same ADDR_W-1 bit increment
   p_split_second_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && mem_ack && word_q && odd_q && mem_be == 2'b10) |=>
      (mem_valid && mem_be == 2'b01 && mem_waddr == $past(mem_waddr) + 1'b1));

   p_byte_lane_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !word_q) |-> ($countones(mem_be) == 1));

   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(mem_valid && mem_ack));
endmodule

bind word_access_unit wau_checker #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .req_size  (req_size),
   .a0_i      (req_addr[0]),
   .mem_valid (mem_valid),
   .mem_ack   (mem_ack),
   .mem_be    (mem_be),
   .mem_waddr (mem_waddr),
   .mem_wdata (mem_wdata),
   .done      (done)
);

// File: tb/word_access_unit_bench.sv
`timescale 1ns/1ps
module word_access_unit_bench;
   typedef struct packed {
      logic        wr;
      logic        sz;
      logic [19:0] addr;
      logic [15:0] wd;
      logic [1:0]  ncyc;
      logic [1:0]  be0;
      logic [18:0] wa0;
      logic [15:0] bd0;
      logic [1:0]  be1;
      logic [18:0] wa1;
      logic [15:0] bd1;
      logic [15:0] rd;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 1'b1, 20'h00100, 16'h625A, 2'd1, 2'b11, 19'h00080, 16'h625A, 2'b00, 19'h0, 16'h0, 16'h0000},
      '{1'b0, 1'b1, 20'h00100, 16'h0000, 2'd1, 2'b11, 19'h00080, 16'h0000, 2'b00, 19'h0, 16'h0, 16'h625A},
      '{1'b1, 1'b1, 20'h00203, 16'hBEEF, 2'd2, 2'b10, 19'h00101, 16'hEF00, 2'b01, 19'h00102, 16'h00BE, 16'h0000},
      '{1'b0, 1'b1, 20'h00203, 16'h0000, 2'd2, 2'b10, 19'h00101, 16'h0000, 2'b01, 19'h00102, 16'h0000, 16'hBEEF},
      '{1'b0, 1'b0, 20'h00203, 16'h0000, 2'd1, 2'b10, 19'h00101, 16'h0000, 2'b00, 19'h0, 16'h0, 16'h00EF},
      '{1'b0, 1'b0, 20'h00204, 16'h0000, 2'd1, 2'b01, 19'h00102, 16'h0000, 2'b00, 19'h0, 16'h0, 16'h00BE},
      '{1'b1, 1'b0, 20'h00300, 16'h0012, 2'd1, 2'b01, 19'h00180, 16'h0012, 2'b00, 19'h0, 16'h0, 16'h0000},
      '{1'b1, 1'b0, 20'h00301, 16'h0034, 2'd1, 2'b10, 19'h00180, 16'h3400, 2'b00, 19'h0, 16'h0, 16'h0000},
      '{1'b0, 1'b1, 20'h00300, 16'h0000, 2'd1, 2'b11, 19'h00180, 16'h0000, 2'b00, 19'h0, 16'h0, 16'h3412},
      '{1'b0, 1'b1, 20'h002FF, 16'h0000, 2'd2, 2'b10, 19'h0017F, 16'h0000, 2'b01, 19'h00180, 16'h0000, 16'h1200}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0, req_size = 1'b0;
   logic [19:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic        req_ready, done, mem_valid, mem_write, mem_ack;
   logic [15:0] rdata, mem_wdata, mem_rdata;
   logic [18:0] mem_waddr;
   logic [1:0]  mem_be;

   int checks = 0, errors = 0;
   int wait_n = 0, wcnt = 0;
   int nlog = 0, ndone = 0;
   logic [1:0]  log_be [256];
   logic [18:0] log_wa [256];
   logic [15:0] log_wd [256];
   logic [7:0]  mem [4096] = '{default: 8'h00};
   logic [15:0] last_rd = 16'h0000;

   always #4 clk = ~clk;

   word_access_unit u_word_access_unit (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
      .req_ready(req_ready), .done(done), .rdata(rdata), .mem_valid(mem_valid),
      .mem_write(mem_write), .mem_waddr(mem_waddr), .mem_be(mem_be),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
   );

   assign mem_ack   = mem_valid && (wcnt >= wait_n);
   assign mem_rdata = {mem[{mem_waddr[10:0], 1'b1}], mem[{mem_waddr[10:0], 1'b0}]};

   always @(posedge clk) begin
      if (done) ndone <= ndone + 1;
      if (mem_valid && !mem_ack) wcnt <= wcnt + 1;
      else wcnt <= 0;
      if (mem_valid && mem_ack) begin
         log_be[nlog[7:0]] <= mem_be;
         log_wa[nlog[7:0]] <= mem_waddr;
         log_wd[nlog[7:0]] <= mem_wdata;
         nlog <= nlog + 1;
         if (mem_write && mem_be[0]) mem[{mem_waddr[10:0], 1'b0}] <= mem_wdata[7:0];
         if (mem_write && mem_be[1]) mem[{mem_waddr[10:0], 1'b1}] <= mem_wdata[15:8];
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic run_vec(input vec_t v, input bit intrude);
      int base, dbase, lat;
      string tg;
      if (!v.sz) tg = "R7";
      else if (v.addr[0]) tg = "R3";
      else tg = "R2";
      @(negedge clk);
      chk("R10 ready before request", {31'd0, req_ready}, 32'd1);
      base = nlog; dbase = ndone;
      req_valid = 1'b1; req_write = v.wr; req_size = v.sz;
      req_addr = v.addr; req_wdata = v.wd;
      @(posedge clk);
      @(negedge clk);
      if (intrude) begin
         req_valid = 1'b1; req_write = 1'b1; req_size = 1'b1;
         req_addr = 20'h00500; req_wdata = 16'hDEAD;
      end else req_valid = 1'b0;
      lat = 0;
      while (!done && lat < 1000) begin
         @(negedge clk);
         lat++;
      end
      req_valid = 1'b0;
      chk("R8 latency", lat, v.ncyc * (wait_n + 1));
      chk({tg, " bus cycle count"}, nlog - base, {30'd0, v.ncyc});
      chk({tg, " first enables"}, {30'd0, log_be[base[7:0]]}, {30'd0, v.be0});
      chk({tg, " first address"}, {13'd0, log_wa[base[7:0]]}, {13'd0, v.wa0});
      chk({tg, " first data"}, {16'd0, log_wd[base[7:0]]}, {16'd0, v.bd0});
      if (v.ncyc == 2'd2) begin
         chk("R4 second enables", {30'd0, log_be[base[7:0] + 8'd1]}, {30'd0, v.be1});
         chk("R4 second address", {13'd0, log_wa[base[7:0] + 8'd1]}, {13'd0, v.wa1});
         chk("R4 second data", {16'd0, log_wd[base[7:0] + 8'd1]}, {16'd0, v.bd1});
      end
      if (!v.wr) begin
         chk(v.sz ? "R5 read data" : "R7 read data", {16'd0, rdata}, {16'd0, v.rd});
         last_rd = v.rd;
      end else begin
         chk("R8 rdata held on write", {16'd0, rdata}, {16'd0, last_rd});
      end
      @(negedge clk);
      @(negedge clk);
      chk("R8 single done pulse", ndone - dbase, 1);
      chk("R10 no extra bus cycle", nlog - base, {30'd0, v.ncyc});
      chk("R8 rdata stable", {16'd0, rdata}, {16'd0, last_rd});
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      vec_t d;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 ready", {31'd0, req_ready}, 32'd1);
      chk("R1 mem_valid", {31'd0, mem_valid}, 32'd0);
      chk("R1 done", {31'd0, done}, 32'd0);
      chk("R1 rdata", {16'd0, rdata}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 idle after reset", {31'd0, mem_valid}, 32'd0);

      for (int i = 0; i < NV; i++) run_vec(VECS[i], 1'b0);

      // R6: wrap at the top of the byte address space
      d = '{1'b1, 1'b1, 20'hFFFFF, 16'hA1B2, 2'd2, 2'b10, 19'h7FFFF, 16'hB200, 2'b01, 19'h00000, 16'h00A1, 16'h0000};
      run_vec(d, 1'b0);
      d = '{1'b0, 1'b0, 20'h00000, 16'h0000, 2'd1, 2'b01, 19'h00000, 16'h0000, 2'b00, 19'h0, 16'h0, 16'h00A1};
      run_vec(d, 1'b0);
      d = '{1'b0, 1'b1, 20'hFFFFF, 16'h0000, 2'd2, 2'b10, 19'h7FFFF, 16'h0000, 2'b01, 19'h00000, 16'h0000, 16'hA1B2};
      run_vec(d, 1'b0);

      // R9: wait states on every bus cycle
      wait_n = 3;
      run_vec(VECS[3], 1'b0);
      run_vec(VECS[1], 1'b0);
      wait_n = 0;

      // R10: stray write presented while busy is ignored
      run_vec(VECS[3], 1'b1);
      d = '{1'b0, 1'b1, 20'h00500, 16'h0000, 2'd1, 2'b11, 19'h00280, 16'h0000, 2'b00, 19'h0, 16'h0, 16'h0000};
      run_vec(d, 1'b0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule